// File: doc/BRIEF.md
# RAM Window Address Decoder

This block sits in a memory controller beside an 8 MB RAM address region. It holds one 32-bit RAM-size configuration register. A 3-bit window code inside that register selects how much of the region answers as real memory and how much floats as high-impedance. Everything above that point is treated as unmapped. The register can be read back in full at any time.

Every CPU access address is sorted by combinational logic into one of four classes: RAM, high-Z, unmapped, or outside the RAM region. The classification comes from the window code held in the register. For the CPU port, the block also produces three signals:
- a RAM write enable, which lets writes reach memory only inside real RAM;
- a drive-all-ones indication for reads that land in the high-Z area;
- a bus-error signal for accesses that land in the unmapped area.

DMA channels present a start address and a byte length before each transfer. If the transfer would reach past the current mapped RAM limit, the channel's busy bit is cleared and a sticky per-channel error flag is set. A later channel start clears that flag.

Top module: `ram_window_decode`

## Requirements
- R1: After reset the register reads 0x00000B88, the window code (bits 11:9) is 5, and `mapped_limit` is 0x800000, so all 8 MB is RAM.
- R2: A register write stores all 32 bits. `cfg_rdata` returns the last written word from the cycle after the write strobe.
- R3: The window code sets the RAM size and the end of the high-Z area, both in MB:
  - code 0: RAM 1, high-Z end 1
  - code 1: RAM 4, high-Z end 4
  - code 2: RAM 1, high-Z end 2
  - code 3: RAM 4, high-Z end 8
  - code 4: RAM 2, high-Z end 2
  - code 5: RAM 8, high-Z end 8
  - code 6: RAM 2, high-Z end 4
  - code 7: RAM 8, high-Z end 8

  `mapped_limit` equals the RAM size in bytes.
- R4: `cpu_class` is 0 (RAM) for an offset below the RAM size. It is 1 (high-Z) for an offset below the high-Z end. It is 2 (unmapped) for any other offset below 8 MB. The offset is the address bits 28:0.
- R5: Addresses whose top three bits are 000, 100 or 101 decode identically by offset. Any other top bits, or an offset of 8 MB or more, give `cpu_class` 3 (outside).
- R6: A register write that leaves bits 11:9 unchanged does not alter `mapped_limit` or `cpu_class`.
- R7: `cpu_ones` is high only for a valid read in class 1. `cpu_ram_we` is high only for a valid write in class 0.
- R8: `cpu_bus_err` is high in the same cycle as a valid access of class 2, and low otherwise.
- R9: When `dma_chk` is high and (address bits 28:0) + `dma_len` ≥ `mapped_limit`, the selected channel's `dma_err` bit is set and its `dma_busy` bit is cleared on the next edge. A check that stays below the limit changes nothing.
- R10: A `dma_err` bit holds until a `dma_start` for its channel, which clears it and sets busy. An error on the same channel in the same cycle takes priority over a start.
- R11: With window code 4, a 2048-byte transfer starting at 0x001FFF04 raises a DMA error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| cpu_valid | input | 1 | CPU access present |
| cpu_write | input | 1 | CPU access is a write |
| cpu_addr | input | 32 | CPU access address |
| cpu_class | output | 2 | 0 RAM, 1 high-Z, 2 unmapped, 3 outside |
| cpu_ram_we | output | 1 | Write may reach RAM |
| cpu_ones | output | 1 | Read data must be all ones |
| cpu_bus_err | output | 1 | Unmapped access error |
| mapped_limit | output | 24 | Current RAM size in bytes |
| dma_chk | input | 1 | DMA range check strobe |
| dma_chan | input | CW | Channel being checked |
| dma_addr | input | 32 | DMA start address |
| dma_len | input | LEN_W | DMA length in bytes |
| dma_start | input | 1 | Channel start strobe |
| dma_start_chan | input | CW | Channel being started |
| dma_busy | output | NCH | Per-channel busy bits |
| dma_err | output | NCH | Per-channel sticky error bits |

## Verification
A corrupted window code shows up at once on `mapped_limit`. From that cycle, every address near a window boundary is misclassified on `cpu_class`, `cpu_ones` and `cpu_bus_err`. A window code that is wrongly reloaded on a write touching other bits would change these outputs one cycle after the write. A bad DMA comparison, such as strict greater-than instead of greater-or-equal, appears only when a transfer ends exactly on the limit. It is visible on `dma_err` one edge after the check. Error flags that fail to hold would appear as a cleared `dma_err` with no start strobe applied.

// File: rtl/ram_window_decode.sv
`timescale 1ns/1ps
module ram_window_decode #(
  parameter int NCH = 7,
  parameter int LEN_W = 24,
  parameter logic [31:0] RST_VAL = 32'h0000_0B88,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             cpu_valid,
  input  logic             cpu_write,
  input  logic [31:0]      cpu_addr,
  output logic [1:0]       cpu_class,
  output logic             cpu_ram_we,
  output logic             cpu_ones,
  output logic             cpu_bus_err,
  output logic [23:0]      mapped_limit,
  input  logic             dma_chk,
  input  logic [CW-1:0]    dma_chan,
  input  logic [31:0]      dma_addr,
  input  logic [LEN_W-1:0] dma_len,
  input  logic             dma_start,
  input  logic [CW-1:0]    dma_start_chan,
  output logic [NCH-1:0]   dma_busy,
  output logic [NCH-1:0]   dma_err
);
  localparam int OW = 29;
  localparam logic [OW-1:0] MB = OW'(32'h0010_0000);
  localparam logic [OW-1:0] MIRROR = OW'(32'h0080_0000);

  logic [31:0]   reg_q;
  logic [2:0]    win_q;
  logic [OW-1:0] ram_lim, hz_end, off;
  logic          seg_ok;
  logic [OW:0]   dma_end;
  logic          dma_over;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_q <= RST_VAL;
      win_q <= RST_VAL[11:9];
    end else if (cfg_we) begin
      reg_q <= cfg_wdata;
      if (cfg_wdata[11:9] != win_q) win_q <= cfg_wdata[11:9];
    end
  end

  assign cfg_rdata = reg_q;

  always_comb begin
    case (win_q)
      3'd0:    begin ram_lim = MB;      hz_end = MB;      end
      3'd1:    begin ram_lim = 4 * MB;  hz_end = 4 * MB;  end
      3'd2:    begin ram_lim = MB;      hz_end = 2 * MB;  end
      3'd3:    begin ram_lim = 4 * MB;  hz_end = MIRROR;  end
      3'd4:    begin ram_lim = 2 * MB;  hz_end = 2 * MB;  end
      3'd6:    begin ram_lim = 2 * MB;  hz_end = 4 * MB;  end
      default: begin ram_lim = MIRROR;  hz_end = MIRROR;  end
    endcase
  end

  assign mapped_limit = ram_lim[23:0];

  assign off    = cpu_addr[28:0];
  assign seg_ok = (cpu_addr[31:29] == 3'b000) || (cpu_addr[31:29] == 3'b100) ||
                  (cpu_addr[31:29] == 3'b101);

  always_comb begin
    if (!seg_ok || off >= MIRROR) cpu_class = 2'd3;
    else if (off < ram_lim)       cpu_class = 2'd0;
    else if (off < hz_end)        cpu_class = 2'd1;
    else                          cpu_class = 2'd2;
  end

  assign cpu_ram_we  = cpu_valid && cpu_write && (cpu_class == 2'd0);
  assign cpu_ones    = cpu_valid && !cpu_write && (cpu_class == 2'd1);
  assign cpu_bus_err = cpu_valid && (cpu_class == 2'd2);

  assign dma_end  = {1'b0, dma_addr[28:0]} + (OW+1)'(dma_len);
  assign dma_over = dma_end >= {1'b0, ram_lim};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dma_busy[g] <= 1'b0;
        dma_err[g]  <= 1'b0;
      end else if (dma_chk && dma_over && dma_chan == CW'(g)) begin
        dma_busy[g] <= 1'b0;
        dma_err[g]  <= 1'b1;
      end else if (dma_start && dma_start_chan == CW'(g)) begin
        dma_busy[g] <= 1'b1;
        dma_err[g]  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ram_window_decode_chk.sv
`timescale 1ns/1ps
module ram_window_decode_chk #(
  parameter int NCH = 7,
  parameter int LEN_W = 24,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [31:0]      cfg_wdata,
  input logic [31:0]      cfg_rdata,
  input logic             cpu_valid,
  input logic             cpu_write,
  input logic [1:0]       cpu_class,
  input logic             cpu_ram_we,
  input logic             cpu_ones,
  input logic             cpu_bus_err,
  input logic [23:0]      mapped_limit,
  input logic             dma_chk,
  input logic [CW-1:0]    dma_chan,
  input logic [31:0]      dma_addr,
  input logic [LEN_W-1:0] dma_len,
  input logic             dma_start,
  input logic [NCH-1:0]   dma_err
);
  // R3
  limit_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mapped_limit) == 1 && mapped_limit >= 24'h10_0000);

  // R6
  window_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_wdata[11:9] == cfg_rdata[11:9] |=> $stable(mapped_limit));

  // R7
  ram_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ram_we |-> cpu_valid && cpu_write && cpu_class == 2'd0);

  // R7
  ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ones |-> cpu_valid && !cpu_write && cpu_class == 2'd1);

  // R8
  bus_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_bus_err |-> cpu_valid && cpu_class == 2'd2);

  // R9
  dma_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_chk && int'(dma_chan) < NCH &&
    ({1'b0, dma_addr[28:0]} + 30'(dma_len) >= {6'b0, mapped_limit})
    |=> dma_err[$past(dma_chan)]);

  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_chk && !dma_start |=> $stable(dma_err));
endmodule

bind ram_window_decode ram_window_decode_chk #(.NCH(NCH), .LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
  .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_class(cpu_class),
  .cpu_ram_we(cpu_ram_we), .cpu_ones(cpu_ones), .cpu_bus_err(cpu_bus_err),
  .mapped_limit(mapped_limit), .dma_chk(dma_chk), .dma_chan(dma_chan),
  .dma_addr(dma_addr), .dma_len(dma_len), .dma_start(dma_start), .dma_err(dma_err)
);

// File: tb/ram_window_decode_test.sv
`timescale 1ns/1ps
module ram_window_decode_test;
  localparam int NCH = 7;
  localparam int LEN_W = 24;
  localparam int CW = 3;
  localparam int MB = 32'h10_0000;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [31:0] cfg_wdata = 0; logic [31:0] cfg_rdata;
  logic cpu_valid = 0, cpu_write = 0; logic [31:0] cpu_addr = 0;
  logic [1:0] cpu_class; logic cpu_ram_we, cpu_ones, cpu_bus_err;
  logic [23:0] mapped_limit;
  logic dma_chk = 0; logic [CW-1:0] dma_chan = 0; logic [31:0] dma_addr = 0;
  logic [LEN_W-1:0] dma_len = 0; logic dma_start = 0; logic [CW-1:0] dma_start_chan = 0;
  logic [NCH-1:0] dma_busy, dma_err;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  ram_window_decode #(.NCH(NCH), .LEN_W(LEN_W)) uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int ram_mb(int c);
    case (c) 0, 2: return 1; 4, 6: return 2; 1, 3: return 4; default: return 8; endcase
  endfunction
  function automatic int hz_mb(int c);
    case (c) 0: return 1; 2, 4: return 2; 1, 6: return 4; default: return 8; endcase
  endfunction
  function automatic logic [1:0] exp_class(logic [31:0] a, int c);
    int o = int'(a[28:0]);
    if (!(a[31:29] inside {3'b000, 3'b100, 3'b101}) || o >= 8 * MB) return 2'd3;
    if (o < ram_mb(c) * MB) return 2'd0;
    if (o < hz_mb(c) * MB) return 2'd1;
    return 2'd2;
  endfunction

  task automatic wr_cfg(logic [31:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic probe(logic [31:0] a, logic w);
    @(negedge clk); cpu_valid = 1; cpu_write = w; cpu_addr = a; #1;
  endtask

  task automatic dma_check(int ch, logic [31:0] a, int len);
    @(negedge clk); dma_chk = 1; dma_chan = CW'(ch); dma_addr = a; dma_len = LEN_W'(len);
    @(negedge clk); dma_chk = 0; #1;
  endtask

  task automatic dma_go(int ch);
    @(negedge clk); dma_start = 1; dma_start_chan = CW'(ch);
    @(negedge clk); dma_start = 0; #1;
  endtask

  task automatic t_reset;
    #1;
    check("R1 rdata", cfg_rdata, 32'h0000_0B88);
    check("R1 limit", 32'(mapped_limit), 32'h80_0000);
    probe(32'h007F_FFFC, 0);
    check("R1 top of RAM", 32'(cpu_class), 0);
    check("R1 dma_err", 32'(dma_err), 0);
  endtask

  task automatic t_readback;
    wr_cfg(32'hDEAD_BA88); #1;
    check("R2 readback", cfg_rdata, 32'hDEAD_BA88);
    check("R2 window 5", 32'(mapped_limit), 32'h80_0000);
  endtask

  task automatic t_windows;
    for (int c = 0; c < 8; c++) begin
      wr_cfg(32'h188 | (c << 9)); #1;
      check($sformatf("R3 limit code %0d", c), 32'(mapped_limit), ram_mb(c) * MB);
      for (int k = 0; k < 5; k++) begin
        int o;
        case (k)
          0: o = ram_mb(c) * MB - 4;
          1: o = ram_mb(c) * MB;
          2: o = hz_mb(c) * MB - 1;
          3: o = hz_mb(c) * MB;
          default: o = 8 * MB - 1;
        endcase
        if (o < 8 * MB) begin
          probe(o, 0);
          check($sformatf("R4 code %0d off %h", c, o), 32'(cpu_class), 32'(exp_class(o, c)));
          check("R7 ones", 32'(cpu_ones), 32'(exp_class(o, c) == 2'd1));
          check("R8 bus_err", 32'(cpu_bus_err), 32'(exp_class(o, c) == 2'd2));
          cpu_write = 1; #0.5;
          check("R7 ram_we", 32'(cpu_ram_we), 32'(exp_class(o, c) == 2'd0));
          check("R7 write ones", 32'(cpu_ones), 0);
          cpu_valid = 0;
        end
      end
    end
  endtask

  task automatic t_segments;
    wr_cfg(32'h0000_0D88);
    for (int k = 0; k < 3; k++) begin
      logic [31:0] base = (k == 0) ? 32'h0 : (k == 1) ? 32'h8000_0000 : 32'hA000_0000;
      probe(base | 32'h0010_0000, 0);
      check("R5 seg RAM", 32'(cpu_class), 0);
      probe(base | 32'h0030_0000, 0);
      check("R5 seg high-Z", 32'(cpu_class), 1);
      probe(base | 32'h0050_0000, 0);
      check("R5 seg unmapped", 32'(cpu_class), 2);
    end
    probe(32'hC000_0000, 0);
    check("R5 other seg", 32'(cpu_class), 3);
    probe(32'h0080_0000, 0);
    check("R5 past mirror", 32'(cpu_class), 3);
    check("R8 outside no err", 32'(cpu_bus_err), 0);
    cpu_valid = 0;
  endtask

  task automatic t_other_bits;
    wr_cfg(32'h0000_0888);
    wr_cfg(32'hFFFF_F9FF); #1;
    check("R6 limit", 32'(mapped_limit), 32'h20_0000);
    check("R6 rdata", cfg_rdata, 32'hFFFF_F9FF);
    probe(32'h0020_0000, 0);
    check("R6 class", 32'(cpu_class), 2);
    cpu_valid = 0;
  endtask

  task automatic t_dma;
    wr_cfg(32'h0000_0B88);
    dma_go(1); dma_go(2);
    check("R10 start busy", 32'(dma_busy), 32'b110);
    dma_check(1, 32'h0000_1000, 2048);
    check("R9 below no err", 32'(dma_err), 0);
    check("R9 below busy", 32'(dma_busy), 32'b110);
    dma_check(1, 32'h007F_F7FF, 2048);
    check("R9 end below limit", 32'(dma_err), 0);
    dma_check(1, 32'h007F_F800, 2048);
    check("R9 end at limit err", 32'(dma_err), 32'b010);
    check("R9 busy cleared", 32'(dma_busy), 32'b100);
    dma_check(3, 32'h0000_0000, 16);
    check("R10 err held", 32'(dma_err), 32'b010);
    dma_go(1);
    check("R10 start clears err", 32'(dma_err), 0);
    check("R10 start sets busy", 32'(dma_busy), 32'b110);
    @(negedge clk); dma_chk = 1; dma_chan = 2; dma_addr = 32'h007F_FFFF; dma_len = 4;
    dma_start = 1; dma_start_chan = 2;
    @(negedge clk); dma_chk = 0; dma_start = 0; #1;
    check("R10 err beats start", 32'(dma_err), 32'b100);
  endtask

  task automatic t_case4;
    dma_go(0);
    dma_check(0, 32'h001F_FF04, 2048);
    check("R11 window 5 ok", 32'(dma_err[0]), 0);
    wr_cfg(32'h0000_0988);
    dma_check(0, 32'h001F_FF04, 2048);
    check("R11 window 4 err", 32'(dma_err[0]), 1);
    check("R11 busy cleared", 32'(dma_busy[0]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_readback();
    t_windows();
    t_segments();
    t_other_bits();
    t_dma();
    t_case4();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule